// File: doc/BRIEF.md
# Privilege-Aware Virtual Address Segment Decoder

This block sits between the load/store address generator and the translation lookaside buffer of a 32-bit processor. For every access it looks at the virtual address, the privilege mode the core is running in, the error-level status bit and the direction of the access. It then settles one of three outcomes. The access can go to the TLB. It can be translated directly, with a fixed offset removed from the address. Or it can be refused as an address error.

The TLB is looked up in parallel with the decode. Its hit, valid and dirty flags and its physical address come back in the same cycle as the access, and the decoder folds them into the final result. When the access fails, the decoder also produces the exception code, a refill flag that tells the vectoring logic to use the refill entry point, and the new contents of the three fault registers: the faulting address, the page-table context word and the translation entry-high word. All results appear one clock after the access is presented.

Top module: `vaddr_seg_decoder`

## Requirements
- R1: With the error-level bit clear, an address below 0x80000000 is routed to the TLB (route code 0) in every privilege mode.
- R2: With the error-level bit set, an address below 0x80000000 is translated directly (route code 1) with physical equal to virtual. Reads and writes both complete without a fault, and the TLB flags are ignored.
- R3: In kernel mode (mode code 2), an address in 0x80000000..0x9FFFFFFF is translated directly to the address minus 0x80000000.
- R4: In kernel mode, an address in 0xA0000000..0xBFFFFFFF is translated directly to the address minus 0xA0000000.
- R5: In user mode (code 0) or supervisor mode (code 1), any address in 0x80000000..0xBFFFFFFF is an address error (route code 2).
- R6: An address in 0xC0000000..0xDFFFFFFF is routed to the TLB in supervisor or kernel mode, and is an address error in user mode.
- R7: An address at or above 0xE0000000 is routed to the TLB only in kernel mode; in every other mode it is an address error.
- R8: Mode code 3 is given user rights.
- R9: An address error raises exception code 5 on a write and 4 on a read, with the refill flag clear.
- R10: On a TLB route, a miss raises code 3 on a write and 2 on a read with the refill flag set. A hit on an entry whose valid flag is clear raises the same codes with the refill flag clear.
- R11: A write that hits a valid entry whose dirty flag is clear raises code 1. A read of a valid entry, or a write to a valid dirty one, raises no fault (code 0) and returns the TLB's physical address. Any faulting access returns physical address 0.
- R12: On every faulting access, the fault registers load as follows. The bad-address register takes the virtual address. The context word keeps input bits [31:23], holds address bits [31:13] in bits [22:4], and has bits [3:0] zero. The entry-high word is the address with bits [12:0] cleared, ORed with the current ASID.
- R13: A result is flagged valid exactly one cycle after each access and never otherwise. Result fields change only on an access, and the fault registers change only on a faulting access.
- R14: After reset the valid flag, all result fields and all fault registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_vaddr | input | 32 | Virtual address |
| acc_mode | input | 2 | Privilege: 0 user, 1 supervisor, 2 kernel, 3 treated as user |
| acc_erl | input | 1 | Error-level status bit |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| cur_asid | input | 8 | Current address-space identifier |
| ctx_in | input | 32 | Present value of the context register |
| tlb_hit | input | 1 | Parallel TLB lookup matched |
| tlb_valid | input | 1 | Valid flag of the matched half-entry |
| tlb_dirty | input | 1 | Dirty (writable) flag of the matched half-entry |
| tlb_paddr | input | 32 | Physical address from the TLB |
| res_valid | output | 1 | Result of the previous cycle's access |
| res_route | output | 2 | 0 TLB, 1 direct, 2 address error |
| res_paddr | output | 32 | Physical address (0 on a fault) |
| res_exc | output | 5 | Exception code (0 none) |
| res_refill | output | 1 | Fault was a TLB miss |
| res_fault | output | 1 | Access faulted |
| bad_vaddr | output | 32 | Faulting virtual address |
| context_out | output | 32 | New context register value |
| entryhi_out | output | 32 | New entry-high value |

## Verification
The assertions check on every cycle that the result valid flag tracks the access one cycle later. They also check that the identity map applies under the error level, that the top segment is refused outside kernel mode, that address errors and refills carry only their own codes, and that the fault registers load or hold as they should. Other properties need the bench's reference model compared cycle by cycle: the exact segment boundaries such as 0x9FFFFFFF against 0xA0000000, the offset removed in each unmapped window, the treatment of mode 3, the packing of the context word and the entry-high word, and that the TLB flags have no effect outside a TLB route.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;

  localparam int VA_W = 32;

  typedef enum logic [1:0] {
    RT_TLB    = 2'd0,
    RT_DIRECT = 2'd1,
    RT_ERROR  = 2'd2
  } route_t;

  typedef enum logic [4:0] {
    EX_NONE = 5'd0,
    EX_MOD  = 5'd1,
    EX_TLBL = 5'd2,
    EX_TLBS = 5'd3,
    EX_ADEL = 5'd4,
    EX_ADES = 5'd5
  } exc_t;

  typedef enum logic [1:0] {
    PM_USER   = 2'd0,
    PM_SUPER  = 2'd1,
    PM_KERNEL = 2'd2,
    PM_RSVD   = 2'd3
  } pmode_t;

  // Unmapped windows: the top three bits are stripped.
  function automatic logic [VA_W-1:0] strip_window(input logic [VA_W-1:0] va);
    return va & 32'h1FFF_FFFF;
  endfunction

  // Context word: upper field kept, address page-pair number in [22:4].
  function automatic logic [VA_W-1:0] pack_context(input logic [VA_W-1:0] ctx,
                                                    input logic [VA_W-1:0] va);
    logic [VA_W-1:0] keep;
    keep = ctx & 32'hFF80_0000;
    return keep | {9'd0, va[31:13], 4'd0};
  endfunction

endpackage

// File: rtl/seg_classify.sv
module seg_classify
  import vaseg_pkg::*;
(
  input  logic [VA_W-1:0] va,
  input  pmode_t          mode,
  input  logic            erl,
  output route_t          route,
  output logic [VA_W-1:0] direct_pa
);

  logic is_kernel;
  logic is_super;

  assign is_kernel = (mode == PM_KERNEL);
  assign is_super  = (mode == PM_SUPER);

  always_comb begin
    route     = RT_ERROR;
    direct_pa = '0;
    unique case (va[31:29])
      3'd0, 3'd1, 3'd2, 3'd3: begin
        if (erl) begin
          route     = RT_DIRECT;
          direct_pa = va;
        end else begin
          route = RT_TLB;
        end
      end
      3'd4, 3'd5: begin
        if (is_kernel) begin
          route     = RT_DIRECT;
          direct_pa = strip_window(va);
        end
      end
      3'd6: begin
        if (is_kernel || is_super) route = RT_TLB;
      end
      default: begin
        if (is_kernel) route = RT_TLB;
      end
    endcase
  end

endmodule

// File: rtl/fault_encode.sv
module fault_encode
  import vaseg_pkg::*;
(
  input  route_t route,
  input  logic   write,
  input  logic   tlb_hit,
  input  logic   tlb_valid,
  input  logic   tlb_dirty,
  output exc_t   exc,
  output logic   refill,
  output logic   fault
);

  always_comb begin
    exc    = EX_NONE;
    refill = 1'b0;
    unique case (route)
      RT_ERROR: exc = write ? EX_ADES : EX_ADEL;
      RT_TLB: begin
        if (!tlb_hit) begin
          exc    = write ? EX_TLBS : EX_TLBL;
          refill = 1'b1;
        end else if (!tlb_valid) begin
          exc = write ? EX_TLBS : EX_TLBL;
        end else if (write && !tlb_dirty) begin
          exc = EX_MOD;
        end
      end
      default: exc = EX_NONE;
    endcase
    fault = (exc != EX_NONE);
  end

endmodule

// File: rtl/fault_regs.sv
module fault_regs
  import vaseg_pkg::*;
#(
  parameter int ASID_W    = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] asid,
  input  logic [VA_W-1:0]   ctx_in,
  output logic [VA_W-1:0]   bad_vaddr,
  output logic [VA_W-1:0]   context_out,
  output logic [VA_W-1:0]   entryhi_out
);

  localparam logic [VA_W-1:0] PAIR_MASK = ~((VA_W'(1) << (PAGE_BITS + 1)) - VA_W'(1));

  logic [VA_W-1:0] ehi_next;
  assign ehi_next = (va & PAIR_MASK) | {{(VA_W-ASID_W){1'b0}}, asid};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_vaddr   <= '0;
      context_out <= '0;
      entryhi_out <= '0;
    end else if (capture) begin
      bad_vaddr   <= va;
      context_out <= pack_context(ctx_in, va);
      entryhi_out <= ehi_next;
    end
  end

  // R12: a faulting access loads the bad address register
  a_r12_bad_load: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> bad_vaddr == $past(va));

  // R13: fault registers hold when nothing faults
  a_r13_fault_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(bad_vaddr) && $stable(context_out) && $stable(entryhi_out)));

endmodule

// File: rtl/vaddr_seg_decoder.sv
module vaddr_seg_decoder
  import vaseg_pkg::*;
#(
  parameter int ASID_W    = 8,
  parameter int PAGE_BITS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic [31:0]       acc_vaddr,
  input  logic [1:0]        acc_mode,
  input  logic              acc_erl,
  input  logic              acc_write,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic [31:0]       ctx_in,
  input  logic              tlb_hit,
  input  logic              tlb_valid,
  input  logic              tlb_dirty,
  input  logic [31:0]       tlb_paddr,
  output logic              res_valid,
  output logic [1:0]        res_route,
  output logic [31:0]       res_paddr,
  output logic [4:0]        res_exc,
  output logic              res_refill,
  output logic              res_fault,
  output logic [31:0]       bad_vaddr,
  output logic [31:0]       context_out,
  output logic [31:0]       entryhi_out
);

  // Named internal events for the checks below.
  route_t          route_c;
  logic [VA_W-1:0] direct_pa_c;
  exc_t            exc_c;
  logic            refill_c;
  logic            fault_c;
  logic            fault_event;
  logic [VA_W-1:0] pa_c;

  seg_classify u_classify (
    .va        (acc_vaddr),
    .mode      (pmode_t'(acc_mode)),
    .erl       (acc_erl),
    .route     (route_c),
    .direct_pa (direct_pa_c)
  );

  fault_encode u_encode (
    .route     (route_c),
    .write     (acc_write),
    .tlb_hit   (tlb_hit),
    .tlb_valid (tlb_valid),
    .tlb_dirty (tlb_dirty),
    .exc       (exc_c),
    .refill    (refill_c),
    .fault     (fault_c)
  );

  assign fault_event = acc_valid && fault_c;

  always_comb begin
    if (fault_c)                 pa_c = '0;
    else if (route_c == RT_TLB)  pa_c = tlb_paddr;
    else                         pa_c = direct_pa_c;
  end

  fault_regs #(.ASID_W(ASID_W), .PAGE_BITS(PAGE_BITS)) u_fregs (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture     (fault_event),
    .va          (acc_vaddr),
    .asid        (cur_asid),
    .ctx_in      (ctx_in),
    .bad_vaddr   (bad_vaddr),
    .context_out (context_out),
    .entryhi_out (entryhi_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_route  <= '0;
      res_paddr  <= '0;
      res_exc    <= '0;
      res_refill <= 1'b0;
      res_fault  <= 1'b0;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) begin
        res_route  <= route_c;
        res_paddr  <= pa_c;
        res_exc    <= exc_c;
        res_refill <= refill_c;
        res_fault  <= fault_c;
      end
    end
  end

  // R13: result valid follows the access by exactly one cycle
  a_r13_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> res_valid);
  a_r13_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !res_valid);

  // R2: error level gives an identity map on the low half
  a_r2_erl_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_erl && !acc_vaddr[31]) |=>
      (res_route == RT_DIRECT && res_paddr == $past(acc_vaddr) && !res_fault));

  // R7: top segment refused outside kernel mode
  a_r7_top_kernel_only: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_vaddr[31:29] == 3'b111 && acc_mode != 2'd2) |=>
      (res_route == RT_ERROR && res_fault));

  // R9: an address error carries only an address-error code
  a_r9_adr_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_route == RT_ERROR) |->
      ((res_exc == EX_ADEL || res_exc == EX_ADES) && !res_refill));

  // R10: the refill flag only comes with a TLB load or store code
  a_r10_refill_codes: assert property (@(posedge clk) disable iff (!rst_n)
    res_refill |-> (res_exc == EX_TLBL || res_exc == EX_TLBS));

endmodule

// File: tb/vaddr_seg_decoder_bench.sv
module vaddr_seg_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0;
  logic [31:0] acc_vaddr = '0;
  logic [1:0]  acc_mode = '0;
  logic        acc_erl = 1'b0;
  logic        acc_write = 1'b0;
  logic [7:0]  cur_asid = '0;
  logic [31:0] ctx_in = '0;
  logic        tlb_hit = 1'b0;
  logic        tlb_valid = 1'b0;
  logic        tlb_dirty = 1'b0;
  logic [31:0] tlb_paddr = '0;
  logic        res_valid;
  logic [1:0]  res_route;
  logic [31:0] res_paddr;
  logic [4:0]  res_exc;
  logic        res_refill;
  logic        res_fault;
  logic [31:0] bad_vaddr;
  logic [31:0] context_out;
  logic [31:0] entryhi_out;

  always #2 clk = ~clk;

  vaddr_seg_decoder u_vaddr_seg_decoder (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_vaddr(acc_vaddr),
    .acc_mode(acc_mode), .acc_erl(acc_erl), .acc_write(acc_write),
    .cur_asid(cur_asid), .ctx_in(ctx_in), .tlb_hit(tlb_hit),
    .tlb_valid(tlb_valid), .tlb_dirty(tlb_dirty), .tlb_paddr(tlb_paddr),
    .res_valid(res_valid), .res_route(res_route), .res_paddr(res_paddr),
    .res_exc(res_exc), .res_refill(res_refill), .res_fault(res_fault),
    .bad_vaddr(bad_vaddr), .context_out(context_out), .entryhi_out(entryhi_out)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference state
  logic        e_valid = 0;
  int          e_route = 0;
  logic [31:0] e_pa = 0;
  int          e_exc = 0;
  logic        e_refill = 0;
  logic        e_fault = 0;
  logic [31:0] e_bad = 0, e_ctx = 0, e_ehi = 0;
  string       t_route = "R14", t_exc = "R14", t_regs = "R14";

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("R13", "valid", {31'd0, res_valid}, {31'd0, e_valid});
    check(t_route, "route", {30'd0, res_route}, e_route);
    check(t_route, "paddr", res_paddr, e_pa);
    check(t_exc, "exc", {27'd0, res_exc}, e_exc);
    check(t_exc, "refill", {31'd0, res_refill}, {31'd0, e_refill});
    check(t_exc, "fault", {31'd0, res_fault}, {31'd0, e_fault});
    check(t_regs, "badvaddr", bad_vaddr, e_bad);
    check(t_regs, "context", context_out, e_ctx);
    check(t_regs, "entryhi", entryhi_out, e_ehi);
  endtask

  // Behavioural model of one accepted access.
  task automatic model(input logic v, input logic [31:0] va, input logic [1:0] m,
                       input logic erl, input logic wr, input logic [7:0] asid,
                       input logic [31:0] ctx, input logic hit, input logic vld,
                       input logic dty, input logic [31:0] tpa);
    bit kern, sup;
    e_valid = v;
    if (!v) begin
      t_regs = "R13";
      return;
    end
    kern = (m == 2'd2);
    sup  = (m == 2'd1);
    if (va < 32'h8000_0000) begin
      t_route = erl ? "R2" : "R1";
      if (erl) begin e_route = 1; e_pa = va; end
      else e_route = 0;
    end else if (va < 32'hA000_0000) begin
      t_route = kern ? "R3" : "R5";
      if (kern) begin e_route = 1; e_pa = va - 32'h8000_0000; end
      else e_route = 2;
    end else if (va < 32'hC000_0000) begin
      t_route = kern ? "R4" : "R5";
      if (kern) begin e_route = 1; e_pa = va - 32'hA000_0000; end
      else e_route = 2;
    end else if (va < 32'hE000_0000) begin
      t_route = "R6";
      e_route = (kern || sup) ? 0 : 2;
    end else begin
      t_route = "R7";
      e_route = kern ? 0 : 2;
    end
    if (m == 2'd3) t_route = "R8";
    e_refill = 0;
    e_exc = 0;
    if (e_route == 2) begin
      t_exc = "R9";
      e_exc = wr ? 5 : 4;
    end else if (e_route == 0) begin
      if (!hit) begin t_exc = "R10"; e_exc = wr ? 3 : 2; e_refill = 1; end
      else if (!vld) begin t_exc = "R10"; e_exc = wr ? 3 : 2; end
      else if (wr && !dty) begin t_exc = "R11"; e_exc = 1; end
      else begin t_exc = "R11"; e_pa = tpa; end
    end else begin
      t_exc = "R2";
    end
    e_fault = (e_exc != 0);
    if (e_fault) begin
      e_pa = 0;
      t_regs = "R12";
      e_bad = va;
      e_ctx = (ctx & 32'hFF80_0000) | ((va >> 9) & 32'h007F_FFF0);
      e_ehi = (va & 32'hFFFF_E000) | {24'd0, asid};
    end else begin
      t_regs = "R13";
    end
  endtask

  // One cycle: drive at the falling edge, model at the rising edge, compare at the next falling edge.
  task automatic step(input logic v, input logic [31:0] va, input logic [1:0] m,
                      input logic erl, input logic wr, input logic hit,
                      input logic vld, input logic dty);
    acc_valid = v; acc_vaddr = va; acc_mode = m; acc_erl = erl; acc_write = wr;
    tlb_hit = hit; tlb_valid = vld; tlb_dirty = dty;
    tlb_paddr = {va[31:12] ^ 20'h5A5A5, va[11:0]};
    cur_asid = va[7:0] ^ 8'h3C;
    ctx_in = ~va;
    @(posedge clk);
    model(v, va, m, erl, wr, cur_asid, ctx_in, hit, vld, dty, tlb_paddr);
    @(negedge clk);
    compare_all();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R13 watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R14: reset state
    compare_all();
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R1 low half via TLB, hit valid read and miss write
    step(1, 32'h0000_0000, 2'd0, 0, 0, 1, 1, 0);
    step(1, 32'h7FFF_FFFF, 2'd2, 0, 1, 0, 0, 0);
    // R2 error-level identity, TLB flags ignored
    step(1, 32'h7FFF_FFFF, 2'd0, 1, 1, 0, 0, 0);
    step(1, 32'h1234_5678, 2'd1, 1, 0, 0, 1, 0);
    // R3 / R4 boundaries in kernel mode
    step(1, 32'h8000_0000, 2'd2, 0, 0, 0, 0, 0);
    step(1, 32'h9FFF_FFFF, 2'd2, 0, 1, 0, 0, 0);
    step(1, 32'hA000_0000, 2'd2, 0, 0, 0, 0, 0);
    step(1, 32'hBFFF_FFFF, 2'd2, 1, 1, 0, 0, 0);
    // R5 unmapped windows refused to user and supervisor
    step(1, 32'h8000_1000, 2'd0, 0, 0, 1, 1, 1);
    step(1, 32'hBFFF_F000, 2'd1, 0, 1, 1, 1, 1);
    // R13 idle cycles hold results and fault registers
    step(0, 32'hFFFF_FFFF, 2'd0, 0, 1, 0, 0, 0);
    step(0, 32'h0000_2000, 2'd2, 0, 0, 0, 0, 0);
    // R6 supervisor segment
    step(1, 32'hC000_0000, 2'd1, 0, 0, 1, 1, 1);
    step(1, 32'hDFFF_FFFF, 2'd0, 0, 1, 1, 1, 1);
    // R7 top segment
    step(1, 32'hE000_0000, 2'd2, 0, 1, 1, 1, 1);
    step(1, 32'hFFFF_FFFF, 2'd1, 0, 0, 1, 1, 1);
    // R8 mode 3 acts as user
    step(1, 32'hC000_4000, 2'd3, 0, 0, 1, 1, 1);
    step(1, 32'h9000_0000, 2'd3, 0, 1, 1, 1, 1);
    step(1, 32'h0040_0000, 2'd3, 0, 0, 1, 1, 0);
    // R10 invalid entry, R11 modify and dirty write
    step(1, 32'h0040_3000, 2'd0, 0, 0, 1, 0, 1);
    step(1, 32'h0040_5000, 2'd0, 0, 1, 1, 1, 0);
    step(1, 32'h0040_7000, 2'd0, 0, 1, 1, 1, 1);
    // R13 non-faulting access after fault leaves fault registers
    step(1, 32'h8800_0000, 2'd2, 0, 0, 0, 0, 0);

    // Mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [31:0] va;
      va = $urandom;
      step(($urandom % 5) != 0, va, 2'($urandom), ($urandom % 6) == 0,
           1'($urandom), ($urandom % 4) != 0, ($urandom % 4) != 0, 1'($urandom));
    end

    // R14 again: mid-run reset
    acc_valid = 0;
    rst_n = 0;
    e_valid = 0; e_route = 0; e_pa = 0; e_exc = 0; e_refill = 0; e_fault = 0;
    e_bad = 0; e_ctx = 0; e_ehi = 0;
    t_route = "R14"; t_exc = "R14"; t_regs = "R14";
    @(negedge clk);
    compare_all();
    rst_n = 1;
    @(negedge clk);
    compare_all();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule